// File: doc/BRIEF.md
# NAND Host Register Interface

This block is the register bank of a software-driven NAND flash host. A processor reaches it through a byte-wide register port made of an offset, a write strobe, a read strobe, write data and read data. Register writes become levels on the flash control pins and single-byte transfers on the flash I/O bus. Software steps the flash protocol by hand. It raises the command-latch or address-latch level through a control register and then pushes bytes through the data port.

The data port appears at four aliased offsets. A data write places the byte on the flash bus and pulses the active-low write strobe for one cycle. A data read pulses the active-low read strobe for one cycle, and the sampled byte then appears on the read-data output. A two-bit field in the control register selects an error-correction operation, and two of its codes emit a one-cycle clear pulse toward an external ECC engine. A status register reads as a fixed pattern. A pending-event register and a mask register combine into one interrupt request, which is gated by a global enable bit held in the mask.

Top module: `nand_host_regs`

## Requirements
- R1: A write to any of the data offsets 0, 1, 2 or 3 starts a flash byte write.
- R2: The control register is at offset 4. A read of offset 4 returns the last byte written there.
- R3: The flash pins follow control bits from the cycle after the write: bit 0 drives `nf_cle`, bit 1 drives `nf_ale` and bit 7 drives `nf_wp`. Bit 4 set drives `nf_ce_n` low, and bit 4 clear drives it high.
- R4: Control bits [6:5] form the ECC operation field: 2'b11 clear, 2'b10 fetch result, 2'b01 enable, 2'b00 idle. Writing 2'b11 or 2'b01 raises `ecc_clr` for exactly the one cycle after the write. Writing 2'b10 or 2'b00 leaves it low.
- R5: Offset 5 always reads 0x14. Writes to offset 5 have no effect.
- R6: After a data write, `nf_we_n` is low and `nf_io_oe` is high for exactly one cycle, with the written byte on `nf_io_out`. The cycle after that, both return to idle.
- R7: A data read drives `nf_re_n` low for exactly the one cycle after the strobe. The value of `nf_io_in` sampled at the end of that cycle appears on `reg_rdata` from the second cycle after the strobe.
- R8: A data write clears bits 7:1 of the pending-event register and keeps bit 0.
- R9: The pending-event register (offset 6) and the mask register (offset 7) take the written byte. Register reads at offsets 4 to 7 present their value on `reg_rdata` in the cycle after the read strobe.
- R10: `irq` is high exactly when mask bit 7 is set and the bitwise AND of mask and pending-event is nonzero. It follows a register change in the same cycle that the register updates.
- R11: Reset (synchronous, active high) clears the control, pending-event and mask registers. This leaves `nf_ce_n` high, `nf_cle`, `nf_ale` and `nf_wp` low, both strobes high, `ecc_clr` and `irq` low, and `reg_rdata` at zero.
- R12: When `ADDR_W` is greater than 3, offsets of 8 and above read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_wp | output | 1 | Write-protect level |
| nf_we_n | output | 1 | Write strobe to flash, active low |
| nf_re_n | output | 1 | Read strobe to flash, active low |
| nf_io_out | output | 8 | Byte driven toward the flash |
| nf_io_oe | output | 1 | Output enable for the flash bus |
| nf_io_in | input | 8 | Byte returned by the flash |
| ecc_clr | output | 1 | One-cycle clear pulse for the ECC engine |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `ADDR_W` set to 4 rather than the default 3. This opens a window of eight offsets above the register map, so the bench can write and read unmapped locations and confirm that they neither alias the mapped registers nor disturb them. All other widths stay at their defaults. Because of that, every encoding of the two-bit ECC field and every aliased data offset can be driven directly.

// File: rtl/nhr_pkg.sv
package nhr_pkg;

    localparam int BYTE_W = 8;

    // Control register layout: pin levels and the ECC operation field
    typedef enum logic [1:0] {
        ECC_IDLE  = 2'b00,
        ECC_ARM   = 2'b01,
        ECC_FETCH = 2'b10,
        ECC_CLEAR = 2'b11
    } ecc_op_e;

    typedef struct packed {
        logic    wp;      // bit 7
        ecc_op_e ecc;     // bits 6:5
        logic    ce;      // bit 4, active-high chip select request
        logic    spare3;
        logic    spare2;
        logic    ale;     // bit 1
        logic    cle;     // bit 0
    } ctl_t;

    // Offsets 4..7 selected by the low two offset bits
    typedef enum logic [1:0] {
        SEL_CTL  = 2'b00,
        SEL_STAT = 2'b01,
        SEL_PEND = 2'b10,
        SEL_MASK = 2'b11
    } sel_e;

    typedef struct packed {
        logic data_wr;
        logic data_rd;
        logic ctl_wr;
        logic pend_wr;
        logic mask_wr;
    } strobe_t;

    localparam logic [BYTE_W-1:0] STATUS_PATTERN = 8'h14;
    localparam logic [BYTE_W-1:0] PEND_KEEP      = 8'h01;
    localparam int                IRQ_GATE_BIT   = 7;

    function automatic logic ecc_pulses(ecc_op_e op);
        return (op == ECC_ARM) || (op == ECC_CLEAR);
    endfunction

endpackage

// File: rtl/nhr_ctl_reg.sv
module nhr_ctl_reg
    import nhr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output ctl_t              ctl,
    output logic              ecc_clr
);

    ctl_t ctl_q;
    logic clr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            clr_q <= 1'b0;
        end else begin
            clr_q <= 1'b0;
            if (wr) begin
                ctl_q <= ctl_t'(wdata);
                clr_q <= ecc_pulses(ecc_op_e'(wdata[6:5]));
            end
        end
    end

    assign ctl     = ctl_q;
    assign ecc_clr = clr_q;

    // R4
    ecc_clr_source_chk: assert property (@(posedge clk) disable iff (rst)
        ecc_clr |-> $past(wr));

    // R4
    ecc_clr_single_chk: assert property (@(posedge clk) disable iff (rst)
        (ecc_clr && !wr) |=> !ecc_clr);

endmodule

// File: rtl/nhr_irq_ctl.sv
module nhr_irq_ctl
    import nhr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pend_wr,
    input  logic              mask_wr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] pend,
    output logic [BYTE_W-1:0] mask,
    output logic              irq
);

    logic [BYTE_W-1:0] pend_q;
    logic [BYTE_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            if (pend_wr)
                pend_q <= wdata;
            else if (data_wr)
                pend_q <= pend_q & PEND_KEEP;
            if (mask_wr)
                mask_q <= wdata;
        end
    end

    assign pend = pend_q;
    assign mask = mask_q;
    assign irq  = mask_q[IRQ_GATE_BIT] && |(mask_q & pend_q);

    // R8
    pend_data_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !pend_wr) |=> (pend_q[BYTE_W-1:1] == '0));

    // R9
    pend_load_chk: assert property (@(posedge clk) disable iff (rst)
        pend_wr |=> (pend_q == $past(wdata)));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !mask_q[IRQ_GATE_BIT] |-> !irq);

endmodule

// File: rtl/nhr_data_port.sv
module nhr_data_port
    import nhr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic              we_n,
    output logic              re_n,
    output logic [BYTE_W-1:0] io_out,
    output logic              io_oe
);

    logic              we_n_q;
    logic              re_n_q;
    logic              oe_q;
    logic [BYTE_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_n_q <= 1'b1;
            re_n_q <= 1'b1;
            oe_q   <= 1'b0;
            out_q  <= '0;
        end else begin
            we_n_q <= !data_wr;
            re_n_q <= !data_rd;
            oe_q   <= data_wr;
            if (data_wr)
                out_q <= wdata;
        end
    end

    assign we_n   = we_n_q;
    assign re_n   = re_n_q;
    assign io_oe  = oe_q;
    assign io_out = out_q;

    // R6
    we_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n_q |-> ($past(data_wr) && oe_q && (out_q == $past(wdata))));

    // R7
    re_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !re_n_q |-> $past(data_rd));

    // R6
    we_single_chk: assert property (@(posedge clk) disable iff (rst)
        (!we_n_q && !data_wr) |=> (we_n_q && !oe_q));

endmodule

// File: rtl/nand_host_regs.sv
module nand_host_regs
    import nhr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_ce_n,
    output logic              nf_wp,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic [7:0]        nf_io_out,
    output logic              nf_io_oe,
    input  logic [7:0]        nf_io_in,
    output logic              ecc_clr,
    output logic              irq
);

    localparam int MAP_W = 3;

    logic              in_map;
    logic              is_ctl_space;
    sel_e              sel;
    strobe_t           stb;
    ctl_t              ctl;
    logic [BYTE_W-1:0] pend;
    logic [BYTE_W-1:0] mask;
    logic [BYTE_W-1:0] ctl_rd_val;
    logic [BYTE_W-1:0] rdata_q;

    generate
        if (ADDR_W > MAP_W) begin : g_window
            assign in_map = ~|reg_addr[ADDR_W-1:MAP_W];
        end else begin : g_full
            assign in_map = 1'b1;
        end
    endgenerate

    assign is_ctl_space = reg_addr[2];
    assign sel          = sel_e'(reg_addr[1:0]);

    always_comb begin
        stb         = '0;
        stb.data_wr = reg_wr && in_map && !is_ctl_space;
        stb.data_rd = reg_rd && in_map && !is_ctl_space;
        stb.ctl_wr  = reg_wr && in_map && is_ctl_space && (sel == SEL_CTL);
        stb.pend_wr = reg_wr && in_map && is_ctl_space && (sel == SEL_PEND);
        stb.mask_wr = reg_wr && in_map && is_ctl_space && (sel == SEL_MASK);
    end

    always_comb begin
        unique case (sel)
            SEL_CTL:  ctl_rd_val = BYTE_W'(ctl);
            SEL_STAT: ctl_rd_val = STATUS_PATTERN;
            SEL_PEND: ctl_rd_val = pend;
            default:  ctl_rd_val = mask;
        endcase
    end

    nhr_ctl_reg u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr      (stb.ctl_wr),
        .wdata   (reg_wdata),
        .ctl     (ctl),
        .ecc_clr (ecc_clr)
    );

    nhr_irq_ctl u_irq (
        .clk     (clk),
        .rst     (rst),
        .pend_wr (stb.pend_wr),
        .mask_wr (stb.mask_wr),
        .data_wr (stb.data_wr),
        .wdata   (reg_wdata),
        .pend    (pend),
        .mask    (mask),
        .irq     (irq)
    );

    nhr_data_port u_data (
        .clk     (clk),
        .rst     (rst),
        .data_wr (stb.data_wr),
        .data_rd (stb.data_rd),
        .wdata   (reg_wdata),
        .we_n    (nf_we_n),
        .re_n    (nf_re_n),
        .io_out  (nf_io_out),
        .io_oe   (nf_io_oe)
    );

    // Flash capture has priority over a register read in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (!nf_re_n)
            rdata_q <= nf_io_in;
        else if (reg_rd && !in_map)
            rdata_q <= '0;
        else if (reg_rd && is_ctl_space)
            rdata_q <= ctl_rd_val;
    end

    assign reg_rdata = rdata_q;
    assign nf_cle    = ctl.cle;
    assign nf_ale    = ctl.ale;
    assign nf_ce_n   = !ctl.ce;
    assign nf_wp     = ctl.wp;

    // R5
    status_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && in_map && is_ctl_space && sel == SEL_STAT && nf_re_n)
            |=> (reg_rdata == STATUS_PATTERN));

    // R12
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !in_map && nf_re_n) |=> (reg_rdata == '0));

    // R3
    pins_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !stb.ctl_wr |=> ($stable(nf_ce_n) && $stable(nf_cle) && $stable(nf_ale) && $stable(nf_wp)));

endmodule

// File: tb/nand_host_regs_test.sv
module nand_host_regs_test;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] reg_addr;
    logic          reg_wr, reg_rd;
    logic [7:0]    reg_wdata, reg_rdata;
    logic          nf_cle, nf_ale, nf_ce_n, nf_wp, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0]    nf_io_out, nf_io_in;
    logic          ecc_clr, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    nand_host_regs #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_ce_n(nf_ce_n), .nf_wp(nf_wp), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in),
        .ecc_clr(ecc_clr), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    typedef struct packed {
        logic [AW-1:0] wa;
        logic [7:0]    wd;
        logic [AW-1:0] ra;
        logic [7:0]    exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'd4,  8'hA5, 4'd4,  8'hA5},  // R2
        '{4'd4,  8'h00, 4'd4,  8'h00},  // R2
        '{4'd6,  8'h3C, 4'd6,  8'h3C},  // R9
        '{4'd7,  8'hF0, 4'd7,  8'hF0},  // R9
        '{4'd5,  8'hFF, 4'd5,  8'h14},  // R5
        '{4'd7,  8'h00, 4'd7,  8'h00},  // R9
        '{4'd6,  8'hFF, 4'd6,  8'hFF},  // R9
        '{4'd2,  8'h11, 4'd6,  8'h01},  // R8
        '{4'd6,  8'hFE, 4'd6,  8'hFE},  // R9
        '{4'd0,  8'h22, 4'd6,  8'h00},  // R8
        '{4'd12, 8'h77, 4'd4,  8'h00}   // R12
    };

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual 00 expected 01");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0; nf_io_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check("R11 ce_n", nf_ce_n, 1);
        check("R11 cle", nf_cle, 0);
        check("R11 ale", nf_ale, 0);
        check("R11 wp", nf_wp, 0);
        check("R11 we_n", nf_we_n, 1);
        check("R11 re_n", nf_re_n, 1);
        check("R11 ecc_clr", ecc_clr, 0);
        check("R11 irq", irq, 0);
        check("R11 rdata", reg_rdata, 8'h00);
        rd(4'd7);
        check("R11 mask", reg_rdata, 8'h00);
        rd(4'd6);
        check("R11 pend", reg_rdata, 8'h00);

        // table walk: write, then read back
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].wa, VECS[i].wd);
            rd(VECS[i].ra);
            check($sformatf("table %0d", i), reg_rdata, VECS[i].exp);
        end
        rd(4'd13);
        check("R12 unmapped read", reg_rdata, 8'h00);
        rd(4'd9);
        check("R12 unmapped read 9", reg_rdata, 8'h00);

        // R3 pin levels
        wr(4'd4, 8'h93);
        check("R3 cle", nf_cle, 1);
        check("R3 ale", nf_ale, 1);
        check("R3 ce_n", nf_ce_n, 0);
        check("R3 wp", nf_wp, 1);
        check("R4 idle no pulse", ecc_clr, 0);
        wr(4'd4, 8'h02);
        check("R3 cle off", nf_cle, 0);
        check("R3 ale on", nf_ale, 1);
        check("R3 ce_n off", nf_ce_n, 1);
        check("R3 wp off", nf_wp, 0);

        // R4 ECC field
        wr(4'd4, 8'h60);
        check("R4 clear pulse", ecc_clr, 1);
        @(negedge clk);
        check("R4 clear one cycle", ecc_clr, 0);
        wr(4'd4, 8'h20);
        check("R4 arm pulse", ecc_clr, 1);
        @(negedge clk);
        check("R4 arm one cycle", ecc_clr, 0);
        wr(4'd4, 8'h40);
        check("R4 fetch no pulse", ecc_clr, 0);

        // R1 / R6 data write on aliases
        wr(4'd1, 8'h5A);
        check("R6 we_n low", nf_we_n, 0);
        check("R6 oe", nf_io_oe, 1);
        check("R1 byte off1", nf_io_out, 8'h5A);
        @(negedge clk);
        check("R6 we_n back", nf_we_n, 1);
        check("R6 oe back", nf_io_oe, 0);
        wr(4'd3, 8'hC7);
        check("R1 alias 3 we_n", nf_we_n, 0);
        check("R1 byte off3", nf_io_out, 8'hC7);

        // R7 data read
        nf_io_in = 8'hC3;
        rd(4'd0);
        check("R7 re_n low", nf_re_n, 0);
        @(negedge clk);
        check("R7 re_n back", nf_re_n, 1);
        check("R7 captured", reg_rdata, 8'hC3);
        nf_io_in = 8'h96;
        rd(4'd2);
        check("R7 alias 2 re_n", nf_re_n, 0);
        @(negedge clk);
        check("R7 alias 2 byte", reg_rdata, 8'h96);

        // R10 interrupt gating
        wr(4'd7, 8'h01);
        wr(4'd6, 8'h01);
        check("R10 no gate", irq, 0);
        wr(4'd7, 8'h81);
        check("R10 gated on", irq, 1);
        wr(4'd6, 8'h02);
        check("R10 no overlap", irq, 0);
        wr(4'd6, 8'h03);
        check("R10 overlap", irq, 1);
        wr(4'd1, 8'h00);
        check("R10 bit0 kept", irq, 1);
        wr(4'd6, 8'h02);
        wr(4'd7, 8'h82);
        check("R10 bit1", irq, 1);
        wr(4'd0, 8'h00);
        check("R8 R10 cleared", irq, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule